// File: doc/BRIEF.md
# Prescaled sawtooth PWM generator

This block drives one pulse-width-modulated output from a two-level timebase. A prescaler counts system clocks to form one duty unit, and a unit counter ramps from zero up to the period length minus one, then wraps. The output is high while the unit count is below the programmed duty. The result is a waveform whose period is the prescale count times the period length, in clocks. Its high time is the duty times the prescale count.

Software supplies the timebase as one 32-bit word. The low half holds the clocks per unit and the high half holds the units per period. The duty is written through a separate port, in units. Both writes go into holding registers and take effect only when the running period ends, so the output never shows a shortened or stretched pulse. An enable input gates the pin.

Top module: `saw_pwm`

## Requirements
- R1: Bits [15:0] of the config word set the number of system clocks per duty unit (the prescale).
- R2: Bits [31:16] of the config word set the number of duty units per period, so one period lasts prescale times period clocks.
- R3: The unit count starts at 0 at each period start and rises by one every prescale clocks up to period-1. The output is high exactly while the unit count is below the duty, so the high time per period is duty times prescale clocks.
- R4: While oe is low, pwm_out is low; while oe is high, pwm_out follows the waveform.
- R5: Config and duty writes are held and copied into the running registers only on the clock edge that ends a period. A write therefore has no effect on the output before the next period begins.
- R6: A prescale or period value of 0 behaves as 1.
- R7: A duty of 0 keeps the output low for the whole period. A duty equal to or above the period keeps it high for the whole period.
- R8: A synchronous reset (rst high) clears both counters and sets the held and running values to prescale 1, period 1 and duty 0, so the output is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Config write strobe |
| cfg_data | input | 32 | Config word: [15:0] prescale, [31:16] period |
| duty_we | input | 1 | Duty write strobe |
| duty_data | input | 16 | Duty in units |
| oe | input | 1 | Output enable |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that rst is applied for at least one clock before any other activity. They also assume that the running prescale and period are never zero, because the block substitutes 1 for zero at the moment of writing. The range and step properties depend on that assumption. The stimulus keeps prescale and period small, from 0 to 7 and 0 to 12, so that many period boundaries fall inside each run. It includes zero values on purpose, and it draws duties up to two above the period so that both saturation cases occur. Writes and enable changes land on the falling edge, at random points within a period, so the hold-until-boundary behaviour is tested away from the wrap as well as on it.

// File: rtl/saw_pwm.sv
module saw_pwm #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [2*W-1:0] cfg_data,
  input  logic           duty_we,
  input  logic [W-1:0]   duty_data,
  input  logic           oe,
  output logic           pwm_out
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] hold_pre, hold_per, hold_duty;
  logic [W-1:0] run_pre, run_per, run_duty;
  logic [W-1:0] tick_cnt, unit_cnt;

  wire [W-1:0] in_pre = cfg_data[W-1:0];
  wire [W-1:0] in_per = cfg_data[2*W-1:W];
  wire tick_end = (tick_cnt == run_pre - ONE);
  wire wrap     = tick_end && (unit_cnt == run_per - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_pre  <= ONE;
      hold_per  <= ONE;
      hold_duty <= '0;
    end else begin
      if (cfg_we) begin
        hold_pre <= (in_pre == '0) ? ONE : in_pre;
        hold_per <= (in_per == '0) ? ONE : in_per;
      end
      if (duty_we) hold_duty <= duty_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_pre  <= ONE;
      run_per  <= ONE;
      run_duty <= '0;
      tick_cnt <= '0;
      unit_cnt <= '0;
    end else if (wrap) begin
      run_pre  <= hold_pre;
      run_per  <= hold_per;
      run_duty <= hold_duty;
      tick_cnt <= '0;
      unit_cnt <= '0;
    end else if (tick_end) begin
      tick_cnt <= '0;
      unit_cnt <= unit_cnt + ONE;
    end else begin
      tick_cnt <= tick_cnt + ONE;
    end
  end

  assign pwm_out = oe & (unit_cnt < run_duty);
endmodule

// File: rtl/saw_pwm_chk.sv
module saw_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         oe,
  input logic         pwm_out,
  input logic [W-1:0] tick_cnt,
  input logic [W-1:0] unit_cnt,
  input logic [W-1:0] run_pre,
  input logic [W-1:0] run_per,
  input logic [W-1:0] run_duty
);
  localparam logic [W-1:0] ONE = W'(1);
  wire last_tick = (tick_cnt == run_pre - ONE);
  wire last_unit = (unit_cnt == run_per - ONE);

  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst) !oe |-> !pwm_out) else $error("oe gate"); // R4
  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst) tick_cnt < run_pre) else $error("tick range"); // R1
  AST_UNIT_RANGE: assert property (@(posedge clk) disable iff (rst) unit_cnt < run_per) else $error("unit range"); // R2
  AST_NONZERO: assert property (@(posedge clk) disable iff (rst) run_pre != '0 && run_per != '0) else $error("zero cfg"); // R6
  AST_SAW_STEP: assert property (@(posedge clk) disable iff (rst) (last_tick && !last_unit) |=> unit_cnt == $past(unit_cnt) + ONE) else $error("saw step"); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst) (last_tick && last_unit) |=> unit_cnt == '0 && tick_cnt == '0) else $error("wrap"); // R3
  AST_HOLD_MID: assert property (@(posedge clk) disable iff (rst) !(last_tick && last_unit) |=> $stable(run_duty) && $stable(run_pre) && $stable(run_per)) else $error("mid-period load"); // R5
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst) (oe && run_duty >= run_per) |-> pwm_out) else $error("full duty"); // R7
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst) (run_duty == '0) |-> !pwm_out) else $error("zero duty"); // R7
endmodule

bind saw_pwm saw_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .oe(oe), .pwm_out(pwm_out),
  .tick_cnt(tick_cnt), .unit_cnt(unit_cnt),
  .run_pre(run_pre), .run_per(run_per), .run_duty(run_duty)
);

// File: tb/saw_pwm_tb.sv
`timescale 1ns/1ps
module saw_pwm_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_data = '0;
  logic duty_we = 1'b0;
  logic [15:0] duty_data = '0;
  logic oe = 1'b0;
  logic pwm_out;

  int checks = 0;
  int errors = 0;
  string tag = "R8";

  always #2 clk = ~clk;

  saw_pwm u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .duty_we(duty_we), .duty_data(duty_data), .oe(oe), .pwm_out(pwm_out)
  );

  function automatic logic [15:0] nz(input logic [15:0] v);
    return (v == 16'd0) ? 16'd1 : v;
  endfunction

  function automatic logic exp_level(input logic en, input logic [15:0] u, input logic [15:0] d);
    return en && (u < d);
  endfunction

  // model of the requirements: held values, running values, sawtooth position
  logic [15:0] m_hpre, m_hper, m_hduty, m_pre, m_per, m_duty, m_t, m_u;
  always @(posedge clk) begin
    if (rst) begin
      m_hpre <= 1; m_hper <= 1; m_hduty <= 0;
      m_pre <= 1; m_per <= 1; m_duty <= 0; m_t <= 0; m_u <= 0;
    end else begin
      if (cfg_we) begin m_hpre <= nz(cfg_data[15:0]); m_hper <= nz(cfg_data[31:16]); end
      if (duty_we) m_hduty <= duty_data;
      if (m_t == m_pre - 1 && m_u == m_per - 1) begin
        m_pre <= m_hpre; m_per <= m_hper; m_duty <= m_hduty; m_t <= 0; m_u <= 0;
      end else if (m_t == m_pre - 1) begin
        m_t <= 0; m_u <= m_u + 1;
      end else m_t <= m_t + 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_check();
    @(negedge clk);
    check(tag, pwm_out, exp_level(oe, m_u, m_duty));
    cfg_we = 1'b0; duty_we = 1'b0;
  endtask

  task automatic write_cfg(input logic [15:0] pre, input logic [15:0] per);
    cfg_data = {per, pre}; cfg_we = 1'b1;
  endtask

  task automatic write_duty(input logic [15:0] d);
    duty_data = d; duty_we = 1'b1;
  endtask

  task automatic count_check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: measured %0d expected %0d", req, got, exp);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int high, first_rise;
    process_reset();
    // R8: after reset output low even with oe high
    oe = 1'b1;
    tag = "R8";
    repeat (3) step_check();

    // R1 R2 R3: prescale 3, period 5, duty 2 -> 15-clock period, 6 high
    tag = "R3";
    write_cfg(16'd3, 16'd5); write_duty(16'd2);
    repeat (40) step_check();
    while (pwm_out !== 1'b1) step_check();
    high = 0;
    for (int i = 0; i < 15; i++) begin
      if (pwm_out) high++;
      step_check();
    end
    count_check("R3", high, 6);
    first_rise = (pwm_out === 1'b1) ? 15 : -1;
    count_check("R2", first_rise, 15);

    // R6: zero prescale and period act as 1; duty 1 -> constant high
    tag = "R6";
    write_cfg(16'd0, 16'd0); write_duty(16'd1);
    repeat (30) step_check();
    high = 0;
    for (int i = 0; i < 10; i++) begin if (pwm_out) high++; step_check(); end
    count_check("R6", high, 10);

    // R7: duty zero and duty above period
    tag = "R7";
    write_cfg(16'd2, 16'd4); write_duty(16'd0);
    repeat (30) step_check();
    write_duty(16'd9);
    repeat (30) step_check();

    // R5: duty change mid-period
    tag = "R5";
    write_duty(16'd1);
    repeat (20) step_check();
    while (pwm_out !== 1'b1) step_check();
    write_duty(16'd3);
    repeat (24) step_check();

    // R4: oe toggling
    tag = "R4";
    oe = 1'b0;
    repeat (12) step_check();
    oe = 1'b1;
    repeat (4) step_check();

    // constrained random: R1 R2 R3 R5 R6 R7 mixed
    tag = "R5";
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) write_cfg(16'($urandom_range(0, 7)), 16'($urandom_range(0, 12)));
      else if (r < 8) write_duty(16'($urandom_range(0, 14)));
      else if (r < 10) oe = ~oe;
      step_check();
    end
    oe = 1'b1;
    repeat (200) step_check();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic process_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask
endmodule